// File: doc/BRIEF.md
# Two-Point Delay Calibration Controller

This controller keeps a ramp-and-comparator delay element calibrated against the local reference clock. The delay element is steered by an 8-bit DAC code. A flip-flop clocked by the reference clock samples the delayed edge and produces a raw "late" flag. The flag is asynchronous to the controller, so the controller passes it through its own synchronizer.

Each accepted pulse-per-second event starts one calibration run. The run uses two successive-approximation searches. The first finds the DAC code at which the delay equals one reference period. The second finds the code at which the delay equals two periods. The two codes give a linear model of delay versus code: gain as codes per period, and offset as the code for zero delay. Both are smoothed by an exponential average and published with a one-cycle done pulse.

The analog ramp, DAC, comparator and sampling flip-flop sit outside the block. So does any use of the published coefficients.

Top module: `delay_cal_ctrl`

## Requirements
- R1: After synchronous active-high reset, `dac_code`, `offset_avg` and `gain_avg` are 0, and `busy`, `cal_done`, `cal_valid` and `tgt_two` are all low.
- R2: A high `pps` sampled while idle starts a run, and `busy` is high from the following cycle until the done cycle. A `pps` sampled while busy, including in the cycle that publishes results, is ignored. Once idle again, the very next `pps` is accepted.
- R3: Each search tries bits from MSB to LSB, one trial per bit, 8 trials in all, starting at code 128 (0x80). A trial holds its code for 6 cycles (4 settle plus 2 synchronizer) and then samples the synchronized flag. Flag 1 means the delayed edge was late, and the trial bit is kept. Flag 0 clears the trial bit. The next lower bit is then set for the next trial. With a flag that is 1 up to some code and 0 above it, the result is the largest code whose flag is 1, or 0 if no code gives 1.
- R4: `tgt_two` is low during the first search, which targets a one-period delay. It is high during the second search, which targets a two-period delay, and during the publish cycle. Each search begins with `dac_code` at 128.
- R5: With code1 and code2 as the two search results, the new gain is code2 − code1 and the new offset is 2·code1 − code2. Both are signed 10-bit two's-complement values.
- R6: The first published run after reset loads the averages with the new values directly. Every later run applies avg ← avg + ((new − avg) >>> 3), using a flooring arithmetic shift. The averages do not change between publish cycles.
- R7: `cal_done` is a one-cycle pulse 97 cycles after the cycle in which `pps` was accepted. The averages change in that same cycle. `cal_valid` goes high with the first pulse and stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pps | input | 1 | Pulse-per-second request, synchronous to `clk` |
| late_async | input | 1 | Raw coincidence flag from the sampling flip-flop; 1 = delayed edge late |
| dac_code | output | 8 | Code driving the delay element's DAC |
| tgt_two | output | 1 | 0 = aim at one period, 1 = aim at two periods |
| busy | output | 1 | Calibration run in progress |
| cal_done | output | 1 | One-cycle pulse when new coefficients are published |
| cal_valid | output | 1 | At least one calibration has been published |
| offset_avg | output | 10 | Averaged offset, signed (code for zero delay) |
| gain_avg | output | 10 | Averaged gain, signed (codes per period) |

## Verification
Two events can fall in the same cycle: a new `pps` request and the publication of results. The bench provokes this by holding `pps` high across two whole runs, so a request is present in the publish cycle and in the cycle after it. The behavioural model then expects the publish-cycle request to be dropped and the next one to start a run exactly one cycle later. Every clock, the model's `busy`, `cal_done` and averaged values are compared with the design's outputs, so any early or double start shows up as a mismatch.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int CODE_W = 8;
    localparam int FIT_W  = CODE_W + 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PT1,
        ST_PT2,
        ST_UPD
    } cal_state_e;

    typedef struct packed {
        logic signed [FIT_W-1:0] offset;
        logic signed [FIT_W-1:0] gain;
    } lin_fit_t;

    // Linear model from the one-period code (c1) and the two-period code (c2)
    function automatic lin_fit_t fit_two_point(input logic [CODE_W-1:0] c1,
                                               input logic [CODE_W-1:0] c2);
        lin_fit_t f;
        logic signed [FIT_W-1:0] a;
        logic signed [FIT_W-1:0] b;
        a = signed'({2'b00, c1});
        b = signed'({2'b00, c2});
        f.gain   = b - a;
        f.offset = (a <<< 1) - b;
        return f;
    endfunction

endpackage

// File: rtl/cal_sync.sv
module cal_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cal_sar.sv
module cal_sar #(
    parameter int CODE_W = 8,
    parameter int WAIT   = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              flag,
    output logic [CODE_W-1:0] code,
    output logic              fin,
    output logic [CODE_W-1:0] res
);
    localparam int CNT_W = $clog2(WAIT + 1);
    localparam int BIT_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;

    logic [CNT_W-1:0]  cnt;
    logic [BIT_W-1:0]  bitpos;
    logic              active;
    logic [CODE_W-1:0] mask;
    logic              sample;

    assign mask   = CODE_W'(1) << bitpos;
    assign sample = active && (cnt == CNT_W'(WAIT - 1));
    assign res    = flag ? code : (code & ~mask);
    assign fin    = sample && (bitpos == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            code   <= '0;
            cnt    <= '0;
            bitpos <= '0;
            active <= 1'b0;
        end else if (start) begin
            code   <= CODE_W'(1) << (CODE_W - 1);
            bitpos <= BIT_W'(CODE_W - 1);
            cnt    <= '0;
            active <= 1'b1;
        end else if (sample) begin
            cnt <= '0;
            if (bitpos == '0) begin
                code   <= res;
                active <= 1'b0;
            end else begin
                code   <= res | (mask >> 1);
                bitpos <= bitpos - BIT_W'(1);
            end
        end else if (active) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // R3
    sar_first_trial_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> code == (CODE_W'(1) << (CODE_W - 1)));
    // R3
    sar_settle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !sample && !start) |=> $stable(code));
endmodule

// File: rtl/cal_avg.sv
module cal_avg #(
    parameter int W = 10,
    parameter int K = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic                upd,
    input  logic signed [W-1:0] sample,
    output logic signed [W-1:0] avg
);
    logic signed [W:0]   diff;
    logic signed [W:0]   step;
    logic signed [W-1:0] nxt;

    always_comb begin
        diff = {sample[W-1], sample} - {avg[W-1], avg};
        step = diff >>> K;
        nxt  = avg + step[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)       avg <= '0;
        else if (load) avg <= sample;
        else if (upd)  avg <= nxt;
    end

    // R6
    avg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !upd) |=> $stable(avg));
    // R6
    avg_first_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> avg == $past(sample));
endmodule

// File: rtl/delay_cal_ctrl.sv
module delay_cal_ctrl
    import cal_pkg::*;
#(
    parameter int SETTLE      = 4,
    parameter int SYNC_STAGES = 2,
    parameter int AVG_K       = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    pps,
    input  logic                    late_async,
    output logic [CODE_W-1:0]       dac_code,
    output logic                    tgt_two,
    output logic                    busy,
    output logic                    cal_done,
    output logic                    cal_valid,
    output logic signed [FIT_W-1:0] offset_avg,
    output logic signed [FIT_W-1:0] gain_avg
);
    localparam int WAIT   = SETTLE + SYNC_STAGES;
    localparam int N_COEF = 2;

    cal_state_e        state;
    logic [CODE_W-1:0] code1, code2;
    logic              flag_s;
    logic              sar_start, sar_fin;
    logic [CODE_W-1:0] sar_res;
    lin_fit_t          fit;
    logic              avg_load, avg_upd;
    logic signed [FIT_W-1:0] coef_in  [N_COEF];
    logic signed [FIT_W-1:0] coef_out [N_COEF];

    cal_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(late_async), .q(flag_s)
    );

    assign sar_start = ((state == ST_IDLE) && pps) || ((state == ST_PT1) && sar_fin);

    cal_sar #(.CODE_W(CODE_W), .WAIT(WAIT)) u_sar (
        .clk(clk), .rst(rst), .start(sar_start), .flag(flag_s),
        .code(dac_code), .fin(sar_fin), .res(sar_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            code1     <= '0;
            code2     <= '0;
            cal_done  <= 1'b0;
            cal_valid <= 1'b0;
        end else begin
            cal_done <= 1'b0;
            unique case (state)
                ST_IDLE: if (pps) state <= ST_PT1;
                ST_PT1: if (sar_fin) begin
                    code1 <= sar_res;
                    state <= ST_PT2;
                end
                ST_PT2: if (sar_fin) begin
                    code2 <= sar_res;
                    state <= ST_UPD;
                end
                ST_UPD: begin
                    cal_done  <= 1'b1;
                    cal_valid <= 1'b1;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign fit        = fit_two_point(code1, code2);
    assign avg_load   = (state == ST_UPD) && !cal_valid;
    assign avg_upd    = (state == ST_UPD) && cal_valid;
    assign coef_in[0] = fit.offset;
    assign coef_in[1] = fit.gain;

    for (genvar i = 0; i < N_COEF; i++) begin : g_avg
        cal_avg #(.W(FIT_W), .K(AVG_K)) u_avg (
            .clk(clk), .rst(rst), .load(avg_load), .upd(avg_upd),
            .sample(coef_in[i]), .avg(coef_out[i])
        );
    end

    assign offset_avg = coef_out[0];
    assign gain_avg   = coef_out[1];
    assign busy       = (state != ST_IDLE);
    assign tgt_two    = (state == ST_PT2) || (state == ST_UPD);

    // R2
    pps_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PT1) |=> (state == ST_PT1 || state == ST_PT2));
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cal_done |=> !cal_done);
    // R7
    done_valid_chk: assert property (@(posedge clk) disable iff (rst)
        cal_done |-> (cal_valid && !busy));
    // R4
    second_point_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tgt_two) |-> dac_code == (CODE_W'(1) << (CODE_W - 1)));
endmodule

// File: tb/sim_delay_cal_ctrl.sv
module sim_delay_cal_ctrl;
    logic       clk = 1'b0;
    logic       rst;
    logic       pps;
    logic       late_async;
    logic [7:0] dac_code;
    logic       tgt_two, busy, cal_done, cal_valid;
    logic signed [9:0] offset_avg, gain_avg;

    int base = 2600;
    int step = 9;
    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    delay_cal_ctrl u0 (
        .clk(clk), .rst(rst), .pps(pps), .late_async(late_async),
        .dac_code(dac_code), .tgt_two(tgt_two), .busy(busy),
        .cal_done(cal_done), .cal_valid(cal_valid),
        .offset_avg(offset_avg), .gain_avg(gain_avg)
    );

    // Delay element: delay falls linearly with code; period = 1000 units
    assign late_async = ((base - step * int'(dac_code)) > (tgt_two ? 2000 : 1000));

    function automatic int search_code(int n);
        int r = 0;
        for (int c = 0; c < 256; c++)
            if ((base - step * c) > n * 1000) r = c;
        return r;
    endfunction

    // Behavioural reference model
    bit m_busy, e_done, e_valid;
    int m_cnt, m_c1, m_c2, e_off, e_gain;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; e_done = 0; e_valid = 0; m_cnt = 0;
            e_off = 0; e_gain = 0;
        end else if (!m_busy && pps) begin
            m_busy = 1; m_cnt = 0; e_done = 0;
            m_c1 = search_code(1);
            m_c2 = search_code(2);
        end else if (m_busy) begin
            e_done = 0;
            m_cnt++;
            if (m_cnt == 97) begin
                int g, o;
                g = m_c2 - m_c1;
                o = 2 * m_c1 - m_c2;
                if (!e_valid) begin
                    e_gain = g; e_off = o;
                end else begin
                    e_gain = e_gain + ((g - e_gain) >>> 3);
                    e_off  = e_off + ((o - e_off) >>> 3);
                end
                e_valid = 1; e_done = 1; m_busy = 0;
            end
        end else begin
            e_done = 0;
        end
    end

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            check("R2", "busy", int'(busy), int'(m_busy));
            check("R7", "cal_done", int'(cal_done), int'(e_done));
            check("R7", "cal_valid", int'(cal_valid), int'(e_valid));
            check("R4", "tgt_two", int'(tgt_two), int'(m_busy && m_cnt >= 48));
            check("R6", "offset_avg", int'(offset_avg), e_off);
            check("R5", "gain_avg", int'(gain_avg), e_gain);
            if (m_busy && (m_cnt == 0 || m_cnt == 48))
                check("R3", "first trial code", int'(dac_code), 128);
        end
    end

    task automatic wait_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_pps();
        @(negedge clk) pps = 1'b1;
        @(negedge clk) pps = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        pps = 1'b0;
        wait_cycles(4);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", "dac_code", int'(dac_code), 0);
        check("R1", "offset_avg", int'(offset_avg), 0);
        check("R1", "gain_avg", int'(gain_avg), 0);
        check("R1", "flags", int'({busy, cal_done, cal_valid, tgt_two}), 0);

        // Pattern A: codes 177 and 66; a mid-run pps must be ignored (R2)
        pulse_pps();
        wait_cycles(30);
        pulse_pps();
        wait_cycles(90);
        check("R5", "gain after first run", int'(gain_avg), -111);
        check("R6", "offset first load", int'(offset_avg), 288);

        // Pattern B: every code late -> both codes 255 (R3 upper bound)
        base = 5000; step = 1;
        pulse_pps();
        wait_cycles(110);

        // Pattern C: no code late -> both codes 0 (R3 lower bound)
        base = 500; step = 3;
        pulse_pps();
        wait_cycles(110);

        // Pattern D: codes 219 and 19, negative large gain
        base = 2100; step = 5;
        pulse_pps();
        wait_cycles(110);

        // R2/R7: pps held high through the publish cycle -> back-to-back runs
        base = 2600; step = 9;
        @(negedge clk) pps = 1'b1;
        wait_cycles(250);
        pps = 1'b0;
        wait_cycles(110);
        check("R7", "idle at end", int'(busy), 0);

        finish_run();
    end
endmodule